// File: doc/BRIEF.md
# Packet-ID to VC Input Mapper

This block sits on the receiving side of a router input port. It is used where the link does not carry a virtual-channel number. Each flit arrives tagged with a packet identifier chosen by the sender. Head flits also carry a one-bit packet type and the packet's destination. When a head flit arrives, the mapper picks a free local virtual channel and remembers which identifier owns it. Every later flit with that identifier is steered into the same channel. When the tail flit has been written, the identifier is released and the sender may reuse it.

For each channel the mapper keeps the packet's type bit and an age rank that orders the channels by arrival. The rank has log2(V) bits and is updated in least-recently-used fashion. The mapper uses the rank to keep packets that go to the same destination in order. A channel that holds an unserved header may ask the VC allocator for service only if no older channel holds a header for the same destination. When the switch forwards a flit out of a channel, the mapper returns a credit upstream for that channel. When the forwarded flit is a header, the mapper also returns the packet's type bit upstream as a token. The flit storage and the routing logic are outside this block.

Top module: `pktid_vc_mapper`

## Requirements
- R1: A head flit that arrives while at least one VC is free is assigned the lowest-numbered free VC. One cycle later `wr_valid` is 1 and `wr_vc` gives that VC.
- R2: A non-head flit whose identifier is mapped is steered to the mapped VC, with `wr_valid` high one cycle later. Writing a tail flit releases the mapping. A later non-head flit with an unmapped identifier is dropped, so `wr_valid` stays 0.
- R3: A head flit that arrives while every VC is busy gives a one-cycle `err_no_vc` pulse one cycle later. No write happens and no channel state changes.
- R4: The type bit of a head flit is stored with its VC. When a head flit is forwarded from that VC, `tok_valid` is 1 one cycle later and `tok_type` carries the stored bit. No token is returned otherwise.
- R5: Every forwarded flit gives `cred_valid` = 1 one cycle later, with `cred_vc` equal to the VC it left. No credit is returned in cycles without a forwarded flit.
- R6: Bit v of `va_ok` is 1 only if VC v holds a header that has not yet been forwarded and no older VC holds an unforwarded header with the same destination.
- R7: Age is set by arrival order, not by VC number. A head arrival makes its VC the newest, and every VC that was newer than it moves one step older. With 2 VCs this is a single last-token bit.
- R8: A VC becomes free again when its tail flit is forwarded. A head flit can then be assigned to it from the next cycle on.
- R9: After reset all VCs are free and unmapped. All output strobes and `va_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit arriving on the link |
| in_head | input | 1 | Arriving flit is a header |
| in_tail | input | 1 | Arriving flit is the last of its packet |
| in_pkt_id | input | ID_W | Packet identifier carried by the flit |
| in_type | input | 1 | Packet type, meaningful on headers only |
| in_dest | input | DEST_W | Destination, meaningful on headers only |
| fwd_valid | input | 1 | Switch forwards a flit out of a VC |
| fwd_vc | input | log2(NUM_VC) | VC the forwarded flit leaves |
| fwd_head | input | 1 | Forwarded flit is a header |
| fwd_tail | input | 1 | Forwarded flit is a tail |
| wr_valid | output | 1 | Write the arriving flit into the buffer |
| wr_vc | output | log2(NUM_VC) | VC that receives the write |
| err_no_vc | output | 1 | Header arrived with no free VC |
| va_ok | output | NUM_VC | Per-VC permission to request the VC allocator |
| cred_valid | output | 1 | Credit returned upstream |
| cred_vc | output | log2(NUM_VC) | VC the credit belongs to |
| tok_valid | output | 1 | Type token returned upstream |
| tok_type | output | 1 | Returned type bit |

## Verification
A header can arrive on the link in the same cycle that another VC's header is forwarded to the switch. In that cycle the mapper must assign the new VC and advance the ages. It must also return the credit and the type token of the departing VC, and drop that VC's allocator request. The bench drives both events in one cycle, while the new header has the same destination as the departing one. It then checks `wr_vc`, `cred_vc` and `tok_type`, and checks that `va_ok` lets the new header through at once, because the older same-destination header is gone. Ordering by age rather than by index is checked by sending a header to a lower-numbered VC that is younger than a same-destination header in a higher-numbered VC.

// File: rtl/pidmap_pkg.sv
package pidmap_pkg;
    localparam int DEF_NUM_VC = 4;
    localparam int DEF_ID_W   = 3;
    localparam int DEF_DEST_W = 4;
endpackage

// File: rtl/free_vc_pick.sv
module free_vc_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int v = N - 1; v >= 0; v--) begin
            if (!busy[v]) begin
                found = 1'b1;
                idx   = IW'(v);
            end
        end
    end
endmodule

// File: rtl/id_lookup.sv
module id_lookup #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int KW = 3
) (
    input  logic [N-1:0]         mapped,
    input  logic [N-1:0][KW-1:0] ids,
    input  logic [KW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = mapped[g] && (ids[g] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int v = 0; v < N; v++) begin
            if (match[v]) idx = IW'(v);
        end
    end
endmodule

// File: rtl/age_gate.sv
module age_gate #(
    parameter int N  = 4,
    parameter int RW = 2,
    parameter int DW = 4
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0][DW-1:0] dest,
    input  logic [N-1:0][RW-1:0] rank,
    output logic [N-1:0]         ok
);
    for (genvar g = 0; g < N; g++) begin : g_vc
        logic [N-1:0] older_same;
        for (genvar h = 0; h < N; h++) begin : g_peer
            if (h == g) begin : g_self
                assign older_same[h] = 1'b0;
            end else begin : g_other
                assign older_same[h] = pend[h] && (dest[h] == dest[g])
                                       && (rank[h] < rank[g]);
            end
        end
        assign ok[g] = pend[g] && !(|older_same);
    end
endmodule

// File: rtl/pktid_vc_mapper.sv
module pktid_vc_mapper
    import pidmap_pkg::*;
#(
    parameter int NUM_VC = DEF_NUM_VC,
    parameter int ID_W   = DEF_ID_W,
    parameter int DEST_W = DEF_DEST_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_head,
    input  logic                      in_tail,
    input  logic [ID_W-1:0]           in_pkt_id,
    input  logic                      in_type,
    input  logic [DEST_W-1:0]         in_dest,
    input  logic                      fwd_valid,
    input  logic [$clog2(NUM_VC)-1:0] fwd_vc,
    input  logic                      fwd_head,
    input  logic                      fwd_tail,
    output logic                      wr_valid,
    output logic [$clog2(NUM_VC)-1:0] wr_vc,
    output logic                      err_no_vc,
    output logic [NUM_VC-1:0]         va_ok,
    output logic                      cred_valid,
    output logic [$clog2(NUM_VC)-1:0] cred_vc,
    output logic                      tok_valid,
    output logic                      tok_type
);
    localparam int VC_W = $clog2(NUM_VC);
    localparam logic [VC_W-1:0] RANK_NEWEST = VC_W'(NUM_VC - 1);

    typedef struct packed {
        logic [NUM_VC-1:0]              busy;
        logic [NUM_VC-1:0]              mapped;
        logic [NUM_VC-1:0]              hdr_pend;
        logic [NUM_VC-1:0]              vtype;
        logic [NUM_VC-1:0][ID_W-1:0]    id;
        logic [NUM_VC-1:0][DEST_W-1:0]  dest;
        logic [NUM_VC-1:0][VC_W-1:0]    rank;
        logic                           wr_valid;
        logic [VC_W-1:0]                wr_vc;
        logic                           err;
        logic                           cred_valid;
        logic [VC_W-1:0]                cred_vc;
        logic                           tok_valid;
        logic                           tok_type;
    } st_t;

    st_t st_d, st_q;

    logic            free_found;
    logic [VC_W-1:0] free_idx;
    logic            id_hit;
    logic [VC_W-1:0] hit_idx;
    logic [NUM_VC-1:0] hdr_pend_w;

    free_vc_pick #(.N(NUM_VC), .IW(VC_W)) u_pick (
        .busy  (st_q.busy),
        .found (free_found),
        .idx   (free_idx)
    );

    id_lookup #(.N(NUM_VC), .IW(VC_W), .KW(ID_W)) u_look (
        .mapped (st_q.mapped),
        .ids    (st_q.id),
        .key    (in_pkt_id),
        .hit    (id_hit),
        .idx    (hit_idx)
    );

    age_gate #(.N(NUM_VC), .RW(VC_W), .DW(DEST_W)) u_age (
        .pend (st_q.hdr_pend),
        .dest (st_q.dest),
        .rank (st_q.rank),
        .ok   (va_ok)
    );

    always_comb begin
        st_d            = st_q;
        st_d.wr_valid   = 1'b0;
        st_d.err        = 1'b0;
        st_d.cred_valid = 1'b0;
        st_d.tok_valid  = 1'b0;

        // departure towards the switch
        if (fwd_valid) begin
            st_d.cred_valid = 1'b1;
            st_d.cred_vc    = fwd_vc;
            if (fwd_head) begin
                st_d.tok_valid        = 1'b1;
                st_d.tok_type         = st_q.vtype[fwd_vc];
                st_d.hdr_pend[fwd_vc] = 1'b0;
            end
            if (fwd_tail) begin
                st_d.busy[fwd_vc] = 1'b0;
            end
        end

        // arrival from the link
        if (in_valid) begin
            if (in_head) begin
                if (free_found) begin
                    st_d.wr_valid           = 1'b1;
                    st_d.wr_vc              = free_idx;
                    st_d.busy[free_idx]     = 1'b1;
                    st_d.hdr_pend[free_idx] = 1'b1;
                    st_d.vtype[free_idx]    = in_type;
                    st_d.dest[free_idx]     = in_dest;
                    st_d.id[free_idx]       = in_pkt_id;
                    st_d.mapped[free_idx]   = !in_tail;
                    for (int v = 0; v < NUM_VC; v++) begin
                        if ((VC_W'(v) != free_idx) &&
                            (st_q.rank[v] > st_q.rank[free_idx])) begin
                            st_d.rank[v] = st_q.rank[v] - 1'b1;
                        end
                    end
                    st_d.rank[free_idx] = RANK_NEWEST;
                end else begin
                    st_d.err = 1'b1;
                end
            end else if (id_hit) begin
                st_d.wr_valid = 1'b1;
                st_d.wr_vc    = hit_idx;
                if (in_tail) begin
                    st_d.mapped[hit_idx] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int v = 0; v < NUM_VC; v++) begin
                st_q.rank[v] <= VC_W'(v);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign hdr_pend_w = st_q.hdr_pend;
    assign wr_valid   = st_q.wr_valid;
    assign wr_vc      = st_q.wr_vc;
    assign err_no_vc  = st_q.err;
    assign cred_valid = st_q.cred_valid;
    assign cred_vc    = st_q.cred_vc;
    assign tok_valid  = st_q.tok_valid;
    assign tok_type   = st_q.tok_type;
endmodule

module mapper_checker #(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_head,
    input logic              fwd_valid,
    input logic [VC_W-1:0]   fwd_vc,
    input logic              fwd_head,
    input logic              wr_valid,
    input logic              err_no_vc,
    input logic [NUM_VC-1:0] va_ok,
    input logic              cred_valid,
    input logic [VC_W-1:0]   cred_vc,
    input logic              tok_valid,
    input logic [NUM_VC-1:0] hdr_pend
);
    a_r1_head_served: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_head) |=> (wr_valid ^ err_no_vc));

    a_r3_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_vc |-> !wr_valid);

    a_r5_credit: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> (cred_valid && cred_vc == $past(fwd_vc)));

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |=> !cred_valid);

    a_r4_token: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_head) |=> tok_valid);

    a_r4_no_token: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && fwd_head) |=> !tok_valid);

    a_r6_ok_needs_header: assert property (@(posedge clk) disable iff (!rst_n)
        ((va_ok & ~hdr_pend) == '0));
endmodule

bind pktid_vc_mapper mapper_checker #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_head    (in_head),
    .fwd_valid  (fwd_valid),
    .fwd_vc     (fwd_vc),
    .fwd_head   (fwd_head),
    .wr_valid   (wr_valid),
    .err_no_vc  (err_no_vc),
    .va_ok      (va_ok),
    .cred_valid (cred_valid),
    .cred_vc    (cred_vc),
    .tok_valid  (tok_valid),
    .hdr_pend   (hdr_pend_w)
);

// File: tb/sim_pktid_vc_mapper.sv
`timescale 1ns/1ps
module sim_pktid_vc_mapper;
    localparam int NV = 4;
    localparam int IW = 3;
    localparam int DW = 4;
    localparam int VW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_head = 0, in_tail = 0, in_type = 0;
    logic [IW-1:0] in_pkt_id = '0;
    logic [DW-1:0] in_dest = '0;
    logic fwd_valid = 0, fwd_head = 0, fwd_tail = 0;
    logic [VW-1:0] fwd_vc = '0;
    logic wr_valid, err_no_vc, cred_valid, tok_valid, tok_type;
    logic [VW-1:0] wr_vc, cred_vc;
    logic [NV-1:0] va_ok;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pktid_vc_mapper #(.NUM_VC(NV), .ID_W(IW), .DEST_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_pkt_id(in_pkt_id), .in_type(in_type), .in_dest(in_dest),
        .fwd_valid(fwd_valid), .fwd_vc(fwd_vc), .fwd_head(fwd_head), .fwd_tail(fwd_tail),
        .wr_valid(wr_valid), .wr_vc(wr_vc), .err_no_vc(err_no_vc), .va_ok(va_ok),
        .cred_valid(cred_valid), .cred_vc(cred_vc),
        .tok_valid(tok_valid), .tok_type(tok_type)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, return just after the rising edge
    task automatic step(input logic iv, ih, it, input int id, input logic ty,
                        input int ds, input logic fv, input int fc,
                        input logic fh, ft);
        @(negedge clk);
        in_valid = iv; in_head = ih; in_tail = it;
        in_pkt_id = IW'(id); in_type = ty; in_dest = DW'(ds);
        fwd_valid = fv; fwd_vc = VW'(fc); fwd_head = fh; fwd_tail = ft;
        @(posedge clk);
        #1;
    endtask

    task automatic flit(input logic h, t, input int id, input logic ty, input int ds);
        step(1, h, t, id, ty, ds, 0, 0, 0, 0);
    endtask

    task automatic fwd(input int vc, input logic h, t);
        step(0, 0, 0, 0, 0, 0, 1, vc, h, t);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic test_reset();
        chk("R9 wr_valid", int'(wr_valid), 0);
        chk("R9 cred_valid", int'(cred_valid), 0);
        chk("R9 tok_valid", int'(tok_valid), 0);
        chk("R9 err_no_vc", int'(err_no_vc), 0);
        chk("R9 va_ok", int'(va_ok), 0);
    endtask

    task automatic test_alloc_steer();
        flit(1, 0, 5, 1, 3);
        chk("R1 head wr_valid", int'(wr_valid), 1);
        chk("R1 head vc", int'(wr_vc), 0);
        flit(0, 0, 5, 0, 0);
        chk("R2 body steered", int'(wr_vc), 0);
        flit(1, 0, 2, 0, 7);
        chk("R1 second head vc", int'(wr_vc), 1);
        flit(0, 1, 5, 0, 0);
        chk("R2 tail wr_valid", int'(wr_valid), 1);
        chk("R2 tail vc", int'(wr_vc), 0);
        flit(0, 0, 5, 0, 0);
        chk("R2 unmapped id dropped", int'(wr_valid), 0);
        flit(0, 1, 2, 0, 0);
        chk("R2 tail id2 vc", int'(wr_vc), 1);
        chk("R6 distinct dests", int'(va_ok), 'b0011);
    endtask

    task automatic test_order();
        flit(1, 1, 1, 0, 3);
        chk("R1 third head vc", int'(wr_vc), 2);
        chk("R6 younger same dest blocked", int'(va_ok), 'b0011);
    endtask

    task automatic test_return();
        fwd(0, 1, 0);
        chk("R5 credit", int'(cred_valid), 1);
        chk("R5 credit vc", int'(cred_vc), 0);
        chk("R4 token", int'(tok_valid), 1);
        chk("R4 token type", int'(tok_type), 1);
        chk("R6 after older leaves", int'(va_ok), 'b0110);
        idle();
        chk("R5 no credit when idle", int'(cred_valid), 0);
        chk("R4 no token when idle", int'(tok_valid), 0);
    endtask

    task automatic test_same_cycle();
        step(1, 1, 1, 4, 1, 3, 1, 2, 1, 0);
        chk("R1 concurrent head vc", int'(wr_vc), 3);
        chk("R5 concurrent credit vc", int'(cred_vc), 2);
        chk("R4 concurrent token", int'(tok_valid), 1);
        chk("R4 concurrent token type", int'(tok_type), 0);
        chk("R6 concurrent va_ok", int'(va_ok), 'b1010);
    endtask

    task automatic test_full();
        flit(1, 1, 6, 0, 9);
        chk("R3 err pulse", int'(err_no_vc), 1);
        chk("R3 no write", int'(wr_valid), 0);
        chk("R3 state unchanged", int'(va_ok), 'b1010);
        idle();
        chk("R3 err one cycle", int'(err_no_vc), 0);
    endtask

    task automatic test_release();
        fwd(0, 0, 1);
        chk("R5 tail credit vc", int'(cred_vc), 0);
        chk("R4 no token on tail", int'(tok_valid), 0);
        flit(1, 1, 6, 0, 9);
        chk("R8 freed vc reused", int'(wr_vc), 0);
        chk("R8 no error", int'(err_no_vc), 0);
    endtask

    task automatic test_age();
        fwd(1, 1, 0);
        chk("R4 token type id2", int'(tok_type), 0);
        fwd(1, 0, 1);
        flit(1, 1, 7, 1, 3);
        chk("R7 head into vc1", int'(wr_vc), 1);
        chk("R7 lower index but newer blocked", int'(va_ok), 'b1001);
        fwd(3, 1, 0);
        chk("R4 token type id4", int'(tok_type), 1);
        chk("R7 newer released", int'(va_ok), 'b0011);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        test_alloc_steer();
        test_order();
        test_return();
        test_same_cycle();
        test_full();
        test_release();
        test_age();
        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule